// File: doc/BRIEF.md
# Averaging ADC Conversion Controller

This block sequences a successive-approximation converter from a word-addressed register interface. A host writes a channel number into the channel-control register. The block then runs a conversion timer on a divided copy of the bus clock. At the end of each sample slot it asks an analog front end for a sample. It can add several samples together and return their rounded mean. The result is cut to the selected resolution, and the block sets a completion flag that can raise an interrupt. A calibration sequence uses the same timer and the same completion flag, and it has a failure flag of its own.

The registers are 32-bit words at these byte offsets: 0x00 channel control, 0x08 status, 0x0C result, 0x14 configuration, 0x18 general control, 0x1C general status. Reads return data in the same cycle. A read of the result register has a side effect at the next clock edge.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the status word, result word and general-status word read zero, and irq and afe_req are low.
- R2: A write to offset 0x00 with bits [4:0] other than 0x1F starts a conversion on that channel. Status bit 0 becomes set exactly D×(6 + 28×N) bus clock edges after the write edge, where D is the clock ratio and N is the sample count.
- R3: A write to offset 0x00 with bits [4:0] = 0x1F aborts any conversion in progress and starts nothing. No completion and no sample request follow it.
- R4: General-control bit 5 set selects averaging, and configuration bits [15:14] = 00/01/10/11 then give N = 4/8/16/32. Bit 5 clear gives N = 1. Exactly N single-cycle afe_req pulses are issued per conversion.
- R5: The result is the sum of the N samples, plus N/2, shifted right by log2(N).
- R6: Configuration bits [3:2] = 00/01/10 keep the low 8/10/12 bits of the result. All other bits of the result read zero.
- R7: Configuration bits [6:5] = 00/01/10/11 set the clock ratio D to 1/2/4/8. Configuration bits [1:0] = 01 doubles D, so the largest ratio is 16.
- R8: A read of offset 0x0C clears status bit 0. Channel-control bit 7 enables the interrupt, and irq is high exactly when status bit 0 is set and that enable is set.
- R9: When configuration bit 16 is clear, a conversion that completes while status bit 0 is still set leaves the result unchanged. When bit 16 is set, the new result replaces the old one.
- R10: Writing general-control bit 7 starts a calibration that lasts as long as a conversion. Bit 7 reads back 1 while calibration runs and clears itself at the end. Calibration issues no afe_req and sets status bit 0 when it finishes.
- R11: A write to offset 0x00 during calibration aborts the calibration and sets general-status bit 1. Starting a new calibration clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| irq | output | 1 | Completion interrupt |
| afe_req | output | 1 | One-cycle sample request to the front end |
| afe_chan | output | 5 | Channel being converted |
| afe_data | input | 12 | Sample value, taken on the afe_req cycle |

## Verification
Some properties are checked on every clock. A sample request never lasts longer than one cycle, and none is issued during calibration. A stop write leaves the timer idle, and a completion always sets the flag. A result read with no completion in the same cycle clears the flag. An unread result is held when overwrite is off, and an abort during calibration sets the fail flag. Other behaviour only the bench scenarios can show: the exact completion cycle for each pairing of clock ratio and sample count, the rounded and masked average produced from known front-end samples, and the request counts. The order of events across calibration, abort and recalibration is also shown only by the bench.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
    typedef enum logic [1:0] {PH_IDLE, PH_FIX, PH_SLOT} phase_e;

    localparam logic [7:0] OFS_CHCTL = 8'h00;
    localparam logic [7:0] OFS_STAT  = 8'h08;
    localparam logic [7:0] OFS_RES   = 8'h0C;
    localparam logic [7:0] OFS_CFG   = 8'h14;
    localparam logic [7:0] OFS_GCTL  = 8'h18;
    localparam logic [7:0] OFS_GSTAT = 8'h1C;
    localparam logic [4:0] CHAN_STOP = 5'h1F;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] src_sel,
    input  logic [1:0] div_sel,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   ratio;
    logic [CNT_W-1:0] term;

    always_comb begin
        ratio = (CNT_W+1)'(1) << ({1'b0, div_sel} + 3'((src_sel == 2'b01) ? 1 : 0));
        term  = CNT_W'(ratio - 1'b1);
        tick  = (cnt_q == term);
        if (restart || tick) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_avg_round.sv
module adc_avg_round #(
    parameter int DATA_W = 12,
    parameter int LOG_MAX = 5,
    localparam int SUM_W = DATA_W + LOG_MAX
) (
    input  logic [SUM_W-1:0]  sum_in,
    input  logic [2:0]        nlog,
    input  logic [1:0]        res_sel,
    output logic [DATA_W-1:0] value
);
    logic [SUM_W:0]      rnd;
    logic [SUM_W:0]      shifted;
    logic [DATA_W-1:0]   mask;
    int                  keep;

    always_comb begin
        rnd = {1'b0, sum_in};
        if (nlog != 3'd0) rnd = rnd + ((SUM_W+1)'(1) << (nlog - 3'd1));
        shifted = rnd >> nlog;
        keep = (res_sel == 2'b11) ? DATA_W : (DATA_W - 4 + 2 * int'(res_sel));
        mask = DATA_W'((64'd1 << keep) - 64'd1);
        value = shifted[DATA_W-1:0] & mask;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int CHAN_W     = 5,
    parameter int FIX_TICKS  = 6,
    parameter int BASE_TICKS = 25,
    parameter int LST_TICKS  = 3,
    parameter int LOG_MAX    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              afe_req,
    output logic [CHAN_W-1:0] afe_chan,
    input  logic [DATA_W-1:0] afe_data
);
    localparam int SLOT_TICKS = BASE_TICKS + LST_TICKS;
    localparam int MAX_PH     = (FIX_TICKS > SLOT_TICKS) ? FIX_TICKS : SLOT_TICKS;
    localparam int TICK_W     = $clog2(MAX_PH);
    localparam int SCNT_W     = LOG_MAX + 1;
    localparam int SUM_W      = DATA_W + LOG_MAX;
    localparam int PRESC_W    = 4;

    typedef struct packed {
        logic              aien;
        logic [CHAN_W-1:0] chan;
        logic [16:0]       cfg;
        logic              avgen;
        phase_e            phase;
        logic              cal;
        logic [TICK_W-1:0] tcnt;
        logic [SCNT_W-1:0] scnt;
        logic [2:0]        nlog;
        logic [SUM_W-1:0]  sum;
        logic [DATA_W-1:0] result;
        logic              flag;
        logic              calfail;
    } st_t;

    st_t st_d, st_q;

    logic              wr, rd, hc_wr, start_conv, stop_wr, cal_start, res_rd;
    logic              tick, slot_end, last_slot, done;
    logic [SUM_W-1:0]  sum_next;
    logic [DATA_W-1:0] avg_val;

    adc_clk_div #(.CNT_W(PRESC_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_conv | cal_start),
        .src_sel (st_q.cfg[1:0]),
        .div_sel (st_q.cfg[6:5]),
        .tick    (tick)
    );

    adc_avg_round #(.DATA_W(DATA_W), .LOG_MAX(LOG_MAX)) u_avg (
        .sum_in  (sum_next),
        .nlog    (st_q.nlog),
        .res_sel (st_q.cfg[3:2]),
        .value   (avg_val)
    );

    function automatic logic [2:0] avg_log(input logic en, input logic [1:0] sel);
        return en ? (3'd2 + {1'b0, sel}) : 3'd0;
    endfunction

    always_comb begin
        wr         = bus_sel & bus_wr;
        rd         = bus_sel & ~bus_wr;
        hc_wr      = wr && (bus_addr == OFS_CHCTL);
        stop_wr    = hc_wr && (bus_wdata[4:0] == CHAN_STOP);
        start_conv = hc_wr && !stop_wr;
        cal_start  = wr && (bus_addr == OFS_GCTL) && bus_wdata[7];
        res_rd     = rd && (bus_addr == OFS_RES);
        slot_end   = (st_q.phase == PH_SLOT) && tick && (st_q.tcnt == TICK_W'(SLOT_TICKS - 1));
        last_slot  = (st_q.scnt == SCNT_W'((7'd1 << st_q.nlog) - 7'd1));
        done       = slot_end && last_slot;
        sum_next   = st_q.sum + SUM_W'(afe_data);

        st_d = st_q;
        if (wr && bus_addr == OFS_CFG)  st_d.cfg   = bus_wdata[16:0];
        if (wr && bus_addr == OFS_GCTL) st_d.avgen = bus_wdata[5];

        unique case (st_q.phase)
            PH_FIX: if (tick) begin
                if (st_q.tcnt == TICK_W'(FIX_TICKS - 1)) begin
                    st_d.phase = PH_SLOT;
                    st_d.tcnt  = '0;
                end else begin
                    st_d.tcnt = st_q.tcnt + 1'b1;
                end
            end
            PH_SLOT: if (tick) begin
                if (slot_end) begin
                    st_d.tcnt = '0;
                    if (!st_q.cal) st_d.sum = sum_next;
                    if (last_slot) st_d.phase = PH_IDLE;
                    else           st_d.scnt  = st_q.scnt + 1'b1;
                end else begin
                    st_d.tcnt = st_q.tcnt + 1'b1;
                end
            end
            default: ;
        endcase

        if (res_rd) st_d.flag = 1'b0;

        if (done) begin
            st_d.flag = 1'b1;
            if (st_q.cal) st_d.cal = 1'b0;
            else if (!st_q.flag || st_q.cfg[16]) st_d.result = avg_val;
        end

        if (hc_wr) begin
            st_d.aien = bus_wdata[7];
            st_d.chan = bus_wdata[4:0];
            if (st_q.cal) begin
                st_d.cal     = 1'b0;
                st_d.calfail = 1'b1;
            end
            st_d.phase = stop_wr ? PH_IDLE : PH_FIX;
            st_d.tcnt  = '0;
            st_d.scnt  = '0;
            st_d.sum   = '0;
            st_d.nlog  = avg_log(st_q.avgen, st_q.cfg[15:14]);
        end else if (cal_start) begin
            st_d.cal     = 1'b1;
            st_d.calfail = 1'b0;
            st_d.phase   = PH_FIX;
            st_d.tcnt    = '0;
            st_d.scnt    = '0;
            st_d.sum     = '0;
            st_d.nlog    = avg_log(bus_wdata[5], st_q.cfg[15:14]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CHCTL: bus_rdata = {24'd0, st_q.aien, 2'd0, st_q.chan};
            OFS_STAT:  bus_rdata = {31'd0, st_q.flag};
            OFS_RES:   bus_rdata = {{(32-DATA_W){1'b0}}, st_q.result};
            OFS_CFG:   bus_rdata = {15'd0, st_q.cfg};
            OFS_GCTL:  bus_rdata = {24'd0, st_q.cal, 1'b0, st_q.avgen, 5'd0};
            OFS_GSTAT: bus_rdata = {30'd0, st_q.calfail, 1'b0};
            default:   bus_rdata = '0;
        endcase
    end

    assign irq      = st_q.flag & st_q.aien;
    assign afe_req  = slot_end && !st_q.cal && !start_conv && !cal_start;
    assign afe_chan = st_q.chan;

    logic unused_bits;
    assign unused_bits = ^{bus_wdata[31:17], bus_wdata[6], bus_wdata[5]};

    logic              cal_w, busy_w, flag_w, calfail_w, ovw_w;
    logic [DATA_W-1:0] result_w;
    assign cal_w     = st_q.cal;
    assign busy_w    = (st_q.phase != PH_IDLE);
    assign flag_w    = st_q.flag;
    assign calfail_w = st_q.calfail;
    assign ovw_w     = st_q.cfg[16];
    assign result_w  = st_q.result;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              afe_req,
    input logic              cal_active,
    input logic              busy,
    input logic              flag,
    input logic              calfail,
    input logic [DATA_W-1:0] result,
    input logic              done,
    input logic              ovw,
    input logic              res_rd,
    input logic              hc_wr,
    input logic              stop_wr
);
    assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        afe_req |=> !afe_req);

    assert_cal_no_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cal_active |-> !afe_req);

    assert_stop_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> !busy);

    assert_done_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flag);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_rd && !done) |=> !flag);

    assert_keep_unread_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag && !ovw) |=> $stable(result));

    assert_abort_fails_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hc_wr && cal_active) |=> calfail);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .afe_req    (afe_req),
    .cal_active (cal_w),
    .busy       (busy_w),
    .flag       (flag_w),
    .calfail    (calfail_w),
    .result     (result_w),
    .done       (done),
    .ovw        (ovw_w),
    .res_rd     (res_rd),
    .hc_wr      (hc_wr),
    .stop_wr    (stop_wr)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, afe_req;
    logic [4:0]  afe_chan;
    logic [11:0] afe_data;

    int applied = 0, failed = 0;
    int req_cnt = 0, base = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    adc_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .afe_req(afe_req), .afe_chan(afe_chan), .afe_data(afe_data)
    );

    // front-end stub: value depends on channel and sample index
    assign afe_data = 12'(int'(afe_chan) * 211 + (req_cnt - base) * 37 + 1000);
    always @(posedge clk) if (afe_req) req_cnt <= req_cnt + 1;

    // chan[4:0] res[1:0] div[1:0] src[1:0] avgen asel[1:0]
    localparam logic [13:0] VEC [6] = '{
        {5'd3,  2'd2, 2'd0, 2'd0, 1'b0, 2'd0},
        {5'd7,  2'd2, 2'd1, 2'd0, 1'b1, 2'd0},
        {5'd12, 2'd0, 2'd0, 2'd0, 1'b1, 2'd1},
        {5'd5,  2'd1, 2'd3, 2'd1, 1'b0, 2'd0},
        {5'd9,  2'd2, 2'd0, 2'd0, 1'b1, 2'd3},
        {5'd21, 2'd1, 2'd2, 2'd0, 1'b1, 2'd2}
    };

    function automatic int expect_val(int chan, int nlog, int res);
        int sum = 0, n = 1 << nlog, avg, bits;
        for (int k = 0; k < n; k++) sum += (chan * 211 + k * 37 + 1000) & 12'hFFF;
        avg = (sum + ((nlog == 0) ? 0 : (1 << (nlog - 1)))) >> nlog;
        bits = (res == 0) ? 8 : (res == 1) ? 10 : 12;
        return avg & ((1 << bits) - 1);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic setup(int res, int dv, int src, int aven, int asel, int ovw);
        bus_write(8'h14, 32'(ovw << 16 | asel << 14 | dv << 5 | res << 2 | src));
        bus_write(8'h18, 32'(aven << 5));
    endtask

    task automatic start(int chan, int aien);
        base = req_cnt;
        bus_write(8'h00, 32'(aien << 7 | chan));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failed++;
        $display("FAIL watchdog actual=running expected=finished");
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
        end
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        bus_read(8'h08, rd); check("R1 status", rd, 0);
        bus_read(8'h0C, rd); check("R1 result", rd, 0);
        bus_read(8'h1C, rd); check("R1 gstat", rd, 0);
        check("R1 irq", irq, 0);
        check("R1 afe_req", afe_req, 0);

        // table walk: R2 R4 R5 R6 R7
        foreach (VEC[i]) begin
            int chan = VEC[i][13:9], res = VEC[i][8:7], dv = VEC[i][6:5];
            int src = VEC[i][4:3], aven = VEC[i][2], asel = VEC[i][1:0];
            int nlog = aven ? 2 + asel : 0;
            int d = (1 << dv) * ((src == 1) ? 2 : 1);
            int t = 6 + 28 * (1 << nlog);
            setup(res, dv, src, aven, asel, 1);
            start(chan, 1);
            repeat (d * t - 1) @(posedge clk);
            #2 check("R2 R7 not yet complete", irq, 0);
            @(posedge clk);
            #2 check("R2 R7 complete on time", irq, 1);
            check("R4 request count", 32'(req_cnt - base), 32'(1 << nlog));
            bus_read(8'h0C, rd);
            check("R5 R6 result", rd, 32'(expect_val(chan, nlog, res)));
            bus_read(8'h08, rd);
            check("R8 read clears flag", rd, 0);
            check("R8 irq drops", irq, 0);
        end

        // R3 stop aborts
        setup(2, 0, 0, 0, 0, 1);
        start(2, 1);
        repeat (10) @(posedge clk);
        bus_write(8'h00, 32'h9F);
        base = req_cnt;
        repeat (100) @(posedge clk);
        #2 check("R3 no irq after stop", irq, 0);
        check("R3 no requests after stop", 32'(req_cnt - base), 0);
        bus_read(8'h08, rd); check("R3 flag stays clear", rd, 0);

        // R8 interrupt gate off
        start(6, 0);
        repeat (40) @(posedge clk);
        #2 check("R8 irq masked", irq, 0);
        bus_read(8'h08, rd); check("R8 flag set while masked", rd, 1);
        bus_read(8'h0C, rd); check("R8 masked result", rd, 32'(expect_val(6, 0, 2)));

        // R9 overwrite disabled keeps unread result
        setup(2, 0, 0, 0, 0, 0);
        start(1, 1);
        repeat (40) @(posedge clk);
        start(30, 1);
        repeat (40) @(posedge clk);
        bus_read(8'h0C, rd); check("R9 old result kept", rd, 32'(expect_val(1, 0, 2)));
        setup(2, 0, 0, 0, 0, 1);
        start(2, 1);
        repeat (40) @(posedge clk);
        start(30, 1);
        repeat (40) @(posedge clk);
        bus_read(8'h0C, rd); check("R9 overwrite replaces", rd, 32'(expect_val(30, 0, 2)));

        // R10 calibration
        base = req_cnt;
        bus_write(8'h18, 32'h80);
        bus_read(8'h18, rd); check("R10 cal bit busy", rd[7], 1);
        repeat (32) @(posedge clk);
        #2 check("R10 cal not yet done", irq, 0);
        @(posedge clk);
        #2 check("R10 cal completes", irq, 1);
        bus_read(8'h18, rd); check("R10 cal bit clears", rd[7], 0);
        bus_read(8'h1C, rd); check("R10 no fail", rd, 0);
        check("R10 no samples", 32'(req_cnt - base), 0);
        bus_read(8'h0C, rd);

        // R11 abort calibration
        bus_write(8'h18, 32'h80);
        repeat (5) @(posedge clk);
        start(4, 1);
        bus_read(8'h1C, rd); check("R11 fail flag set", rd, 2);
        repeat (40) @(posedge clk);
        bus_read(8'h0C, rd); check("R11 conversion after abort", rd, 32'(expect_val(4, 0, 2)));
        bus_write(8'h18, 32'h80);
        bus_read(8'h1C, rd); check("R11 new cal clears fail", rd, 0);
        repeat (40) @(posedge clk);

        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
        end
        $finish;
    end
endmodule